// File: doc/BRIEF.md
# Counted SPI Burst Sequencer

This block lets other logic run a whole SPI exchange of several bytes with a single request. The requester presents a packed vector of transmit bytes, a byte count and the serial mode, then pulses `start` for one cycle. The sequencer copies the bytes into its own buffer, pulls chip select low and hands the bytes one at a time to an embedded single-byte SPI engine. Between bytes it waits for the engine's busy flag to fall, and it files each received byte at the same index as the byte that was just sent.

The byte engine drives the serial clock, MOSI and chip select timing for all four clock polarity and phase combinations. Its clock rate comes from a programmable divider. When the last byte is finished the sequencer releases chip select and pulses `done` for one cycle. The received bytes are then readable on `rx_data`.

Top module: `spi_burst_seq`

## Requirements
- R1: A `start` pulse while idle latches `tx_data`, `byte_count`, `cpol` and `cpha`, then exchanges exactly `byte_count` bytes. Byte k is taken from `tx_data[k*DATA_W +: DATA_W]`. Changes to `tx_data` after the start pulse have no effect on the burst.
- R2: Each byte goes out most significant bit first on `mosi`. Received byte k is stored most significant bit first at `rx_data[k*DATA_W +: DATA_W]`.
- R3: `cs_n` is active low. It falls once before the first SCLK edge of byte 0, stays low without a break until after the last edge of the final byte, and is high whenever the block is idle and when `done` is high.
- R4: SCLK rests at the `cpol` level and gives DATA_W leading edges per byte. With `cpha`=0 the bits are sampled on leading edges, with `cpha`=1 on trailing edges. After every byte SCLK is back at `cpol`.
- R5: Within a byte, consecutive SCLK edges are exactly `clk_div`+1 clock cycles apart.
- R6: `busy` is high from the cycle after `start` until the cycle of `done`. `done` is high for exactly one cycle per burst.
- R7: A `start` pulse that arrives while a burst is in progress is ignored. The running burst keeps its bytes and length, and only one `done` is produced.
- R8: The sequencer issues a send to the byte engine only while the engine is not busy.
- R9: A `byte_count` of 0 produces `done` in the cycle after `start`, with no chip-select or SCLK activity.
- R10: A `byte_count` larger than MAX_BYTES is treated as MAX_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a burst |
| byte_count | input | CNT_W | Number of bytes to exchange |
| cpol | input | 1 | Idle level of SCLK |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| clk_div | input | DIV_W | SCLK half period minus one, in clock cycles |
| tx_data | input | MAX_BYTES*DATA_W | Packed transmit bytes, byte k at slice k |
| rx_data | output | MAX_BYTES*DATA_W | Packed received bytes, byte k at slice k |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at burst end |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |

## Verification
A mode-aware slave model in the bench shifts a known reply pattern onto MISO and captures MOSI. This catches several faults. A design with the sample and shift edges swapped for one CPHA setting receives bytes shifted by one bit. Reversed bit order shows up as mirrored captures. A chip select that lifts between bytes is counted as an extra falling edge. The bench also goes after the divider boundary at zero, where an off-by-one doubles the edge spacing. It sends counts of zero and above the maximum, which a design without clamping or an empty-burst path would hang on or overrun. It sends a second start in mid-burst, which a careless sequencer would use to restart or to emit a second `done`.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ISSUE,
    SQ_WAIT
  } seq_state_t;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int W     = 8,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             send,
  input  logic [W-1:0]     tx_byte,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic [W-1:0]     rx_byte
);
  localparam int EW = $clog2(2*W+1);

  logic          busy_q, sclk_q, tick;
  logic [EW-1:0] tk;
  logic [W-1:0]  tx_sh, rx_sh;
  logic          lead;

  spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(busy_q), .div(div), .tick(tick)
  );

  // tick 0 is set-up time; ticks 1..2W are SCLK edges, odd tick = leading
  assign lead = tk[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tk     <= '0;
      sclk_q <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (!busy_q) begin
      sclk_q <= cpol;
      if (send) begin
        busy_q <= 1'b1;
        tk     <= '0;
        tx_sh  <= tx_byte;
      end
    end else if (tick) begin
      tk <= tk + 1'b1;
      if (tk != '0) begin
        sclk_q <= ~sclk_q;
        if (lead != cpha) rx_sh <= {rx_sh[W-2:0], miso};
        else if (tk != EW'(1)) tx_sh <= {tx_sh[W-2:0], 1'b0};
      end
      if (tk == EW'(2*W)) busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_sh[W-1];
  assign rx_byte = rx_sh;

  // R8: a new byte request never lands on a busy engine
  p_send_idle_r8: assert property (@(posedge clk) disable iff (rst)
    send |-> !busy_q);

  // R4: an even number of toggles leaves SCLK at its rest level
  p_sclk_rest_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (sclk_q == cpol));
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
  import spi_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter int DIV_W     = 4,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int BUS_W    = MAX_BYTES * DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [BUS_W-1:0] tx_data,
  output logic [BUS_W-1:0] rx_data,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  input  logic             miso
);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  seq_state_t        st;
  logic [IDX_W-1:0]  idx, last;
  logic              cs_n_q, done_q, send_q, seen;
  logic              cpol_q, cpha_q;
  logic [DATA_W-1:0] tx_cur;
  logic [CNT_W-1:0]  cnt_c;
  logic              eng_busy, eng_cpol, rx_we, accept;
  logic [DATA_W-1:0] eng_rx;

  logic [DATA_W-1:0] tx_buf [MAX_BYTES];
  logic [DATA_W-1:0] rx_buf [MAX_BYTES];

  assign cnt_c  = (byte_count > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : byte_count;
  assign accept = (st == SQ_IDLE) && start;
  assign rx_we  = (st == SQ_WAIT) && seen && !eng_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SQ_IDLE;
      idx    <= '0;
      last   <= '0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
      send_q <= 1'b0;
      seen   <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      send_q <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          cpol_q <= cpol;
          cpha_q <= cpha;
          idx    <= '0;
          if (cnt_c == '0) done_q <= 1'b1;
          else begin
            last   <= IDX_W'(cnt_c - 1'b1);
            cs_n_q <= 1'b0;
            st     <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          send_q <= 1'b1;
          seen   <= 1'b0;
          st     <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (eng_busy) seen <= 1'b1;
          else if (seen) begin
            if (idx == last) begin
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              st     <= SQ_IDLE;
            end else begin
              idx <= idx + 1'b1;
              st  <= SQ_ISSUE;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // transmit buffer: captured whole on an accepted start
  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_txbuf
    always_ff @(posedge clk) begin
      if (accept) tx_buf[i] <= tx_data[i*DATA_W +: DATA_W];
    end
    assign rx_data[i*DATA_W +: DATA_W] = rx_buf[i];
  end

  // synchronous read of the byte about to be sent
  always_ff @(posedge clk) begin
    if (st == SQ_ISSUE) tx_cur <= tx_buf[idx];
  end

  // single write port into the receive buffer
  always_ff @(posedge clk) begin
    if (rx_we) rx_buf[idx] <= eng_rx;
  end

  assign eng_cpol = (st == SQ_IDLE) ? cpol : cpol_q;

  spi_byte_engine #(.W(DATA_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .send(send_q), .tx_byte(tx_cur),
    .cpol(eng_cpol), .cpha(cpha_q), .div(clk_div), .miso(miso),
    .busy(eng_busy), .sclk(sclk), .mosi(mosi), .rx_byte(eng_rx)
  );

  assign busy = (st != SQ_IDLE);
  assign done = done_q;
  assign cs_n = cs_n_q;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  p_done_cs_high_r3: assert property (@(posedge clk) disable iff (rst)
    done_q |-> cs_n_q);

  p_engine_in_window_r3: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> !cs_n_q);

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
    (start && st != SQ_IDLE) |=> $stable(last));
endmodule

// File: tb/spi_burst_seq_test.sv
module spi_burst_seq_test;
  localparam int DW = 8;
  localparam int MB = 4;
  localparam int DV = 4;
  localparam int CW = $clog2(MB + 1);

  logic clk = 0, rst = 1, start = 0, cpol = 0, cpha = 0, miso = 0;
  logic [CW-1:0]    byte_count = '0;
  logic [DV-1:0]    clk_div = '0;
  logic [MB*DW-1:0] tx_data = '0;
  logic [MB*DW-1:0] rx_data;
  logic busy, done, sclk, mosi, cs_n;

  always #5 clk = ~clk;

  spi_burst_seq #(.DATA_W(DW), .MAX_BYTES(MB), .DIV_W(DV)) uut (
    .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
    .cpol(cpol), .cpha(cpha), .clk_div(clk_div), .tx_data(tx_data),
    .rx_data(rx_data), .busy(busy), .done(done), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] r_seed = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] reply(int k);
    return 8'hC3 ^ 8'(k * 29) ^ r_seed;
  endfunction

  function automatic logic [7:0] txb(int seed, int k);
    return 8'(seed * 13 + k * 71 + 5);
  endfunction

  // slave model
  logic s_psclk = 0, s_pcsn = 1, s_cap_lead;
  int s_ns = 0, s_k = 0, s_leads = 0, s_falls = 0, s_last = -1, s_gap = 1000;
  logic [7:0] s_cap = 0;
  logic [7:0] s_got [MB];
  logic [7:0] s_tmp;

  always @(negedge clk) begin
    cyc++;
    if (s_pcsn && !cs_n) begin
      s_falls++; s_ns = 0; s_k = 0; s_last = -1;
      s_tmp = reply(0);
      if (!cpha) miso = s_tmp[7];
    end else if (!cs_n && sclk != s_psclk) begin
      s_cap_lead = (sclk != cpol);
      if (s_cap_lead) s_leads++;
      if (s_last >= 0 && (cyc - s_last) < s_gap) s_gap = cyc - s_last;
      s_last = cyc;
      if (s_cap_lead == !cpha) begin
        s_cap = {s_cap[6:0], mosi};
        s_ns++;
        if (s_ns == 8) begin
          if (s_k < MB) s_got[s_k] = s_cap;
          s_k++; s_ns = 0; s_last = -1;
        end
      end else begin
        s_tmp = reply(s_k);
        miso = s_tmp[7 - s_ns];
      end
    end
    s_psclk = sclk;
    s_pcsn  = cs_n;
  end

  int d_cnt = 0, d_dbl = 0;
  logic d_prev = 0;
  always @(negedge clk) begin
    if (done) d_cnt++;
    if (done && d_prev) d_dbl++;
    d_prev = done;
  end

  task automatic burst(int pol, int pha, int div, int cnt, int seed, bit late_start);
    int n;
    n = (cnt > MB) ? MB : cnt;
    @(posedge clk); #1;
    cpol = pol[0]; cpha = pha[0]; clk_div = DV'(div); byte_count = CW'(cnt);
    r_seed = 8'(seed * 7);
    for (int k = 0; k < MB; k++) tx_data[k*DW +: DW] = txb(seed, k);
    repeat (3) @(posedge clk);
    #1;
    s_leads = 0; s_falls = 0; s_gap = 1000; d_cnt = 0; d_dbl = 0;
    for (int k = 0; k < MB; k++) s_got[k] = 8'h00;
    start = 1;
    @(posedge clk); #1;
    start = 0;
    chk("R6", 32'(busy), 1, "busy after start");
    tx_data = ~tx_data;  // R1: bytes were already latched
    if (late_start) begin
      repeat (20) @(posedge clk);
      #1; byte_count = CW'(1); start = 1;
      @(posedge clk); #1; start = 0;
    end
    for (int t = 0; t < 20000 && !done; t++) begin
      @(posedge clk); #1;
    end
    chk("R6", 32'(done), 1, "done reached");
    repeat (3) @(posedge clk);
    #1;
    chk("R6", 32'(d_cnt), 1, "done count");
    chk("R6", 32'(d_dbl), 0, "done width");
    chk("R6", 32'(busy), 0, "busy after done");
    chk("R3", 32'(s_falls), 1, "cs falls per burst");
    chk("R3", 32'(cs_n), 1, "cs idle high");
    chk("R4", 32'(sclk), 32'(pol), "sclk rest level");
    chk("R4", 32'(s_leads), 32'(8 * n), "leading edge count");
    chk("R5", 32'(s_gap), 32'(div + 1), "edge spacing");
    for (int k = 0; k < n; k++) begin
      chk("R2", 32'(s_got[k]), 32'(txb(seed, k)), $sformatf("mosi byte %0d", k));
      chk("R2", 32'(rx_data[k*DW +: DW]), 32'(reply(k)), $sformatf("rx byte %0d", k));
    end
    if (late_start) chk("R7", 32'(s_leads), 32'(8 * MB), "late start ignored");
    if (cnt > MB) chk("R10", 32'(s_leads), 32'(8 * MB), "count clamp");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R3", 32'(cs_n), 1, "reset cs_n");
    chk("R6", 32'(busy), 0, "reset busy");
    chk("R6", 32'(done), 0, "reset done");
    rst = 0;
    @(posedge clk); #1;
    chk("R4", 32'(sclk), 0, "reset sclk");

    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++) begin
        burst(m >> 1, m & 1, d * 3, 1, m * 4 + d, 0);
        burst(m >> 1, m & 1, d * 3, MB, m * 4 + d + 9, 0);
      end
    burst(1, 0, 1, 2, 40, 0);
    burst(0, 1, 0, 3, 41, 0);
    burst(0, 0, 2, MB, 42, 1);   // R7
    burst(1, 1, 0, 7, 43, 0);    // R10

    // R9: empty burst
    @(posedge clk); #1;
    byte_count = '0; start = 1; s_falls = 0; s_leads = 0;
    @(posedge clk); #1;
    start = 0;
    chk("R9", 32'(done), 1, "empty burst done");
    chk("R9", 32'(cs_n), 1, "empty burst cs");
    @(posedge clk); #1;
    chk("R9", 32'(done), 0, "empty burst done width");
    chk("R9", 32'(s_falls + s_leads), 0, "empty burst bus quiet");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule